// File: doc/BRIEF.md
# Nibble-Wide Interrupt Request Combiner

This block merges the interrupt requests of a small 4-bit controller into one CPU interrupt line. Four request inputs feed sticky flags: a PortA summary request, a PortC summary request, a timer/counter request, and a prescaler tick. The prescaler tick is taken from one of three rate ticks chosen by a two-bit select. Each flag has its own enable. A global interrupt enable gates the whole output.

Software reaches the block through a small nibble-wide register bus. Reads have no wait states, and some reads have side effects. Reading the main request register clears the two internal flags. The two port flags clear only when the port logic reports that its own request register was read, through the acknowledge inputs.

The global enable is raised by a halt event, unless that halt starts an automatic serial transfer. Entering sleep forces the enable low. Sleep is entered by software writing bit 2 of the main register address, and only when the sleep-permit bit is set. A wake input ends sleep.

Top module: `cor_irq_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when INTEN is 1 and at least one flag is enabled. The enables are: PortA by mask bit 0, PortC by mask bit 1, timer by mask bit 2, and prescaler by a nonzero select. `irq_o` comes from flops only, so it changes at the clock edge that changes that state.
- R2: A read at address 0 returns the flags in the same cycle: bit 3 prescaler, bit 2 timer, bit 1 PortC, bit 0 PortA. Address 1 reads `{sleep_permit, timer_en, portc_en, porta_en}`. Address 2 reads `{0, INTEN, psel[1:0]}`. Address 3 reads 0.
- R3: A read of address 0 clears the prescaler and timer flags at the following edge.
- R4: A read of address 0 leaves the PortA and PortC flags unchanged. `pa_ack_i` clears the PortA flag and `pc_ack_i` clears the PortC flag.
- R5: After reset, all flags, enable bits, select bits, the sleep-permit bit, INTEN, `sleep_o` and `irq_o` are 0.
- R6: Entering sleep drives INTEN to 0 at that edge. While `sleep_o` is 1, INTEN stays 0 and ignores halt events and software writes. `wake_i` clears `sleep_o`.
- R7: When not in sleep, `halt_i` with `halt_xfer_i` low sets INTEN at the next edge, and this wins over a software write of INTEN in the same cycle. A halt with `halt_xfer_i` high leaves INTEN unchanged.
- R8: A write to address 0 with data bit 2 set enters sleep only when the sleep-permit bit is 1. Otherwise the write has no effect.
- R9: When a source event and a clearing read or acknowledge fall in the same cycle, the flag is 1 after the edge, so no request is lost.
- R10: The prescaler flag is set by `pre_tick_i[0]` when psel=01, by `pre_tick_i[1]` when psel=10, and by `pre_tick_i[2]` when psel=11. No tick sets it when psel=00, and unselected ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pa_req_i | input | 1 | PortA summary request pulse |
| pc_req_i | input | 1 | PortC summary request pulse |
| tmr_req_i | input | 1 | Timer/counter request pulse |
| pre_tick_i | input | 3 | Prescaler rate ticks, fastest in bit 0 |
| pa_ack_i | input | 1 | PortA request register was read |
| pc_ack_i | input | 1 | PortC request register was read |
| halt_i | input | 1 | Halt instruction event |
| halt_xfer_i | input | 1 | The halt starts an automatic serial transfer |
| wake_i | input | 1 | Leave sleep mode |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | CPU interrupt level |
| sleep_o | output | 1 | Sleep mode state |

## Verification
Read data is combinational, so it is due in the cycle of the read strobe. The bench samples it 1 ns after driving, before the edge that applies the read's side effect.

Flag, enable and sleep changes take effect at the next rising edge. `irq_o` and `sleep_o` follow at that same edge. The bench therefore updates its model at the edge and compares these outputs at the following falling edge.

INTEN is observed only through address 2 reads. The clearing side effects are observed by reading again one cycle later.

// File: rtl/cor_irq_pkg.sv
package cor_irq_pkg;
  localparam int DW      = 4;
  localparam int N_SRC   = 4;
  localparam int N_RATE  = 3;
  localparam int PSEL_W  = $clog2(N_RATE + 1);
  localparam int SRC_PA  = 0;
  localparam int SRC_PC  = 1;
  localparam int SRC_TM  = 2;
  localparam int SRC_PR  = 3;
  localparam int SLP_BIT = 2;

  typedef enum logic [1:0] {
    A_MAIN = 2'd0,
    A_MASK = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } addr_e;
endpackage

// File: rtl/cor_irq_flags.sv
module cor_irq_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // set beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/cor_irq_cfg.sv
module cor_irq_cfg
  import cor_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mask_i,
  input  logic              wr_ctrl_i,
  input  logic              sleep_req_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              halt_i,
  input  logic              halt_xfer_i,
  input  logic              wake_i,
  output logic [2:0]        src_en_o,
  output logic              slp_permit_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic              inten_o,
  output logic              sleep_o
);
  logic [2:0]        src_en_q;
  logic              slp_permit_q, inten_q, sleep_q, inten_d, sleep_d, enter;
  logic [PSEL_W-1:0] psel_q;

  assign enter = sleep_req_i && slp_permit_q;

  always_comb begin
    sleep_d = sleep_q;
    if (enter)       sleep_d = 1'b1;
    else if (wake_i) sleep_d = 1'b0;

    inten_d = inten_q;
    if (enter || sleep_q)          inten_d = 1'b0;
    else if (halt_i && !halt_xfer_i) inten_d = 1'b1;
    else if (wr_ctrl_i)            inten_d = wdata_i[2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_en_q     <= '0;
      slp_permit_q <= 1'b0;
      psel_q       <= '0;
      inten_q      <= 1'b0;
      sleep_q      <= 1'b0;
    end else begin
      if (wr_mask_i) begin
        src_en_q     <= wdata_i[2:0];
        slp_permit_q <= wdata_i[3];
      end
      if (wr_ctrl_i) psel_q <= wdata_i[PSEL_W-1:0];
      inten_q <= inten_d;
      sleep_q <= sleep_d;
    end
  end

  assign src_en_o     = src_en_q;
  assign slp_permit_o = slp_permit_q;
  assign psel_o       = psel_q;
  assign inten_o      = inten_q;
  assign sleep_o      = sleep_q;

  p_sleep_kills_inten_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> !inten_o);
  p_halt_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !halt_xfer_i && !sleep_o && !sleep_req_i) |=> inten_o);
  p_sleep_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && !slp_permit_o && !sleep_o) |=> !sleep_o);
  p_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !sleep_req_i) |=> !sleep_o);
endmodule

// File: rtl/cor_irq_ctrl.sv
module cor_irq_ctrl
  import cor_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pa_req_i,
  input  logic          pc_req_i,
  input  logic          tmr_req_i,
  input  logic [2:0]    pre_tick_i,
  input  logic          pa_ack_i,
  input  logic          pc_ack_i,
  input  logic          halt_i,
  input  logic          halt_xfer_i,
  input  logic          wake_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          sleep_o
);
  addr_e             addr;
  logic              rd_main, wr_main, wr_mask, wr_ctrl, pre_set, inten, slp_permit;
  logic [2:0]        src_en;
  logic [PSEL_W-1:0] psel;
  logic [N_RATE-1:0] rate_hit;
  logic [N_SRC-1:0]  set, clr, flag, en_vec;

  assign addr    = addr_e'(bus_addr_i);
  assign rd_main = bus_rd_i && addr == A_MAIN;
  assign wr_main = bus_wr_i && addr == A_MAIN;
  assign wr_mask = bus_wr_i && addr == A_MASK;
  assign wr_ctrl = bus_wr_i && addr == A_CTRL;

  // select code r+1 picks tick r; code 0 picks none
  for (genvar r = 0; r < N_RATE; r++) begin : g_rate
    assign rate_hit[r] = pre_tick_i[r] && (psel == PSEL_W'(r + 1));
  end
  assign pre_set = |rate_hit;

  always_comb begin
    set = '0;
    set[SRC_PA] = pa_req_i;
    set[SRC_PC] = pc_req_i;
    set[SRC_TM] = tmr_req_i;
    set[SRC_PR] = pre_set;
    clr = '0;
    clr[SRC_PA] = pa_ack_i;
    clr[SRC_PC] = pc_ack_i;
    clr[SRC_TM] = rd_main;
    clr[SRC_PR] = rd_main;
  end

  cor_irq_flags #(.N(N_SRC)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr),
    .flag_o(flag)
  );

  cor_irq_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_mask_i   (wr_mask),
    .wr_ctrl_i   (wr_ctrl),
    .sleep_req_i (wr_main && bus_wdata_i[SLP_BIT]),
    .wdata_i     (bus_wdata_i),
    .halt_i      (halt_i),
    .halt_xfer_i (halt_xfer_i),
    .wake_i      (wake_i),
    .src_en_o    (src_en),
    .slp_permit_o(slp_permit),
    .psel_o      (psel),
    .inten_o     (inten),
    .sleep_o     (sleep_o)
  );

  assign en_vec = {psel != '0, src_en};
  assign irq_o  = inten && |(flag & en_vec);

  always_comb begin
    unique case (addr)
      A_MAIN:  bus_rdata_o = flag;
      A_MASK:  bus_rdata_o = {slp_permit, src_en};
      A_CTRL:  bus_rdata_o = {1'b0, inten, psel};
      default: bus_rdata_o = '0;
    endcase
  end

  p_irq_needs_inten_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> inten);
  p_port_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_main && flag[SRC_PA] && !pa_ack_i) |=> flag[SRC_PA]);
  p_off_psel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel == '0) |-> !pre_set);
endmodule

// File: tb/cor_irq_ctrl_tb.sv
module cor_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic pa_req, pc_req, tmr_req, pa_ack, pc_ack, halt, hx, wake, wr, rd;
  logic [2:0] tick;
  logic [1:0] addr;
  logic [3:0] wdata, rdata;
  logic irq, slp;
  int n_run = 0, n_fail = 0;

  logic [3:0] m_flag, m_en;   // m_en = {permit, tm, pc, pa}
  logic [1:0] m_psel;
  logic m_inten, m_sleep;

  always #5 clk = ~clk;

  cor_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pa_req_i(pa_req), .pc_req_i(pc_req),
    .tmr_req_i(tmr_req), .pre_tick_i(tick), .pa_ack_i(pa_ack), .pc_ack_i(pc_ack),
    .halt_i(halt), .halt_xfer_i(hx), .wake_i(wake), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .sleep_o(slp));

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_flag;
      2'd1: return m_en;
      2'd2: return {1'b0, m_inten, m_psel};
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_inten && |(m_flag & {m_psel != 2'b0, m_en[2:0]});
  endfunction

  task automatic idle();
    {pa_req, pc_req, tmr_req, pa_ack, pc_ack, halt, hx, wake, wr, rd} = '0;
    tick = 0; addr = 0; wdata = 0;
  endtask

  task automatic m_update();
    logic [3:0] set, clr;
    logic enter;
    set = {m_psel != 0 && tick[m_psel - 2'd1], tmr_req, pc_req, pa_req};
    clr = {rd && addr == 0, rd && addr == 0, pc_ack, pa_ack};
    m_flag = set | (m_flag & ~clr);
    enter = wr && addr == 0 && wdata[2] && m_en[3];
    if (enter || m_sleep) m_inten = 0;
    else if (halt && !hx) m_inten = 1;
    else if (wr && addr == 2) m_inten = wdata[2];
    if (wr && addr == 1) m_en = wdata;
    if (wr && addr == 2) m_psel = wdata[1:0];
    if (enter) m_sleep = 1;
    else if (wake) m_sleep = 0;
  endtask

  // inputs already driven after a negedge
  task automatic step();
    #1;
    if (rd) chk("R2 read data", rdata, m_read(addr));
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk("R1 irq level", {3'b0, irq}, {3'b0, m_irq()});
    chk("R8 sleep state", {3'b0, slp}, {3'b0, m_sleep});
    idle();
  endtask

  task automatic bus(logic w, logic [1:0] a, logic [3:0] d);
    wr = w; rd = !w; addr = a; wdata = d;
    step();
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    m_flag = 0; m_en = 0; m_psel = 0; m_inten = 0; m_sleep = 0;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk("R5 irq reset", {3'b0, irq}, 4'h0);
    chk("R5 sleep reset", {3'b0, slp}, 4'h0);
    for (int a = 0; a < 4; a++) begin
      addr = a[1:0]; #1;
      chk("R5 register reset", rdata, 4'h0);
    end
    rst_n = 1;
    @(negedge clk); idle();

    // R2 bit layout, R3 clear on read, R4 ports kept
    tmr_req = 1; step();
    bus(0, 0, 0); chk("R2 timer at bit 2", m_read(0), 4'h0);
    pa_req = 1; pc_req = 1; step();
    addr = 0; #1; chk("R2 port bits 1:0", rdata, 4'h3);
    bus(0, 0, 0);
    addr = 0; #1; chk("R4 ports survive main read", rdata, 4'h3);
    pa_ack = 1; step();
    addr = 0; #1; chk("R4 PortA ack clears", rdata, 4'h2);
    pc_ack = 1; step();
    addr = 0; #1; chk("R4 PortC ack clears", rdata, 4'h0);

    // R10 prescaler selection
    bus(1, 2, 4'b0010);
    tick = 3'b101; step();
    addr = 0; #1; chk("R10 unselected ticks ignored", rdata, 4'h0);
    tick = 3'b010; step();
    addr = 0; #1; chk("R10 selected tick sets bit 3", rdata, 4'h8);
    bus(0, 0, 0);
    addr = 0; #1; chk("R3 prescaler cleared by read", rdata, 4'h0);

    // R9 set beats clear
    tmr_req = 1; rd = 1; addr = 0; step();
    addr = 0; #1; chk("R9 timer set wins", rdata, 4'h4);
    pa_req = 1; pa_ack = 1; step();
    addr = 0; #1; chk("R9 PortA set wins", rdata, 4'h5);

    // R7 halt behaviour
    halt = 1; hx = 1; step();
    addr = 2; #1; chk("R7 transfer halt leaves INTEN", rdata, 4'h2);
    halt = 1; wr = 1; addr = 2; wdata = 4'h0; step();
    addr = 2; #1; chk("R7 halt beats write", rdata, 4'h4);
    bus(1, 1, 4'h5);
    chk("R1 irq with unmasked flag", {3'b0, irq}, 4'h1);

    // R8 sleep gating, R6 INTEN forced off
    bus(1, 0, 4'h4);
    chk("R8 write without permit ignored", {3'b0, slp}, 4'h0);
    addr = 2; #1; chk("R8 INTEN untouched", rdata, 4'h4);
    bus(1, 1, 4'hD);
    bus(1, 0, 4'h4);
    chk("R6 sleep entered", {3'b0, slp}, 4'h1);
    addr = 2; #1; chk("R6 INTEN cleared on sleep", rdata, 4'h0);
    halt = 1; step();
    addr = 2; #1; chk("R6 halt ignored in sleep", rdata, 4'h0);
    wake = 1; step();
    chk("R6 wake clears sleep", {3'b0, slp}, 4'h0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      pa_req  = ($urandom % 8) == 0;
      pc_req  = ($urandom % 8) == 0;
      tmr_req = ($urandom % 8) == 0;
      tick    = 3'($urandom) & {3{($urandom % 4) == 0}};
      pa_ack  = ($urandom % 6) == 0;
      pc_ack  = ($urandom % 6) == 0;
      halt    = ($urandom % 10) == 0;
      hx      = ($urandom % 2) == 0;
      wake    = ($urandom % 12) == 0;
      addr    = 2'($urandom);
      wdata   = 4'($urandom);
      case ($urandom % 4)
        0: wr = 1;
        1: rd = 1;
        default: ;
      endcase
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule